// File: doc/BRIEF.md
# Multi-Mode Output Driver Register

This block holds an eight-bit output register that software changes over a small word bus with 32-bit data. Software can change the register in three ways. A plain store loads all bits at once. A guarded store replaces only the channels whose protect bit is clear. A per-channel command store gives each channel a 2-bit code that holds, sets, clears or toggles that bit. All three stores are write-only. The register value is read back at its own address.

Each channel also has a route bit. When the route bit is 0, the pin follows the register bit. When it is 1, the pin follows the matching bit of a separate instruction-driven source, which is modelled here as a plain 8-bit input. The route bits can be written and read back. Reads are combinational from the current address. Writes take effect at the rising clock edge on which the write strobe is high.

Top module: `gpo_multimode`

## Requirements
- R1: After reset, the output register, the route register and every pin are 0. Reads at offsets 0x0C and 0x10 return 0.
- R2: A write at offset 0x00 loads the output register from data bits [7:0]. Data bits [31:8] have no effect.
- R3: A write at offset 0x04 carries new values in bits [7:0] and protect bits in bits [15:8]. A channel whose protect bit is 1 keeps its current value. A channel whose protect bit is 0 takes the new value.
- R4: A write at offset 0x08 gives channel n the code in bits [2n+1:2n]. Code 0 holds the bit, 1 sets it, 2 clears it and 3 inverts it. Bits [31:16] have no effect.
- R5: A read at offset 0x0C returns the output register in bits [7:0]. Bits [31:8] read as 0.
- R6: Offset 0x10 holds the route register, one bit per channel. A write loads it from data bits [7:0]. A read returns it in bits [7:0], with bits [31:8] read as 0.
- R7: Pin n equals register bit n when route bit n is 0, and equals instruction-source bit n when route bit n is 1.
- R8: Reads at offsets 0x00, 0x04, 0x08 and at any unmapped address return 0. Writes to unmapped addresses change neither register.
- R9: Both registers change only at a rising clock edge on which the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 5 | Byte address of the word access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| insn_src | input | 8 | Output values from the instruction-driven source |
| pin_out | output | 8 | Per-channel pin values |

## Verification
The guarded store is tried with several protect patterns: half the channels protected, none protected, and all protected. Together these separate a correct keep/take choice from a swapped or ignored mask. The command store uses one word that mixes all four codes across the channels, followed by an all-invert word. This separates each code's meaning and the bit position of each channel's field. Routing is tried with a split route pattern and an instruction value that differs from the register, so a swapped multiplexer leg shows on the pins. A long stretch of random accesses over every mapped and unmapped address is compared each cycle against a behavioural model in the bench.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int unsigned OFS_DIRECT = 0;
  localparam int unsigned OFS_MASKED = 4;
  localparam int unsigned OFS_INDIV  = 8;
  localparam int unsigned OFS_STATUS = 12;
  localparam int unsigned OFS_ROUTE  = 16;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_SET   = 2'd1,
    CMD_CLEAR = 2'd2,
    CMD_FLIP  = 2'd3
  } chan_cmd_e;

  // One channel under a per-channel command code.
  function automatic logic cmd_apply(input logic cur, input logic [1:0] code);
    case (chan_cmd_e'(code))
      CMD_SET:   cmd_apply = 1'b1;
      CMD_CLEAR: cmd_apply = 1'b0;
      CMD_FLIP:  cmd_apply = ~cur;
      default:   cmd_apply = cur;
    endcase
  endfunction

  // One channel under a guarded store: a protect bit of 1 keeps the old value.
  function automatic logic guard_apply(input logic cur, input logic val, input logic keep);
    guard_apply = keep ? cur : val;
  endfunction
endpackage

// File: rtl/gpo_wr_decode.sv
module gpo_wr_decode
  import gpo_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NCH-1:0]    cur_out,
  output logic              hit_direct,
  output logic              hit_masked,
  output logic              hit_indiv,
  output logic              hit_route,
  output logic              hit_none,
  output logic [NCH-1:0]    next_out
);
  localparam int unsigned CMD_W = 2;

  logic [NCH-1:0] guarded_val;
  logic [NCH-1:0] indiv_val;

  assign hit_direct = bus_wr && (bus_addr == ADDR_W'(OFS_DIRECT));
  assign hit_masked = bus_wr && (bus_addr == ADDR_W'(OFS_MASKED));
  assign hit_indiv  = bus_wr && (bus_addr == ADDR_W'(OFS_INDIV));
  assign hit_route  = bus_wr && (bus_addr == ADDR_W'(OFS_ROUTE));
  assign hit_none   = bus_wr && !(hit_direct || hit_masked || hit_indiv || hit_route);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign guarded_val[ch] = guard_apply(cur_out[ch], bus_wdata[ch], bus_wdata[NCH+ch]);
    assign indiv_val[ch]   = cmd_apply(cur_out[ch], bus_wdata[CMD_W*ch +: CMD_W]);
  end

  always_comb begin
    next_out = cur_out;
    if (hit_direct)      next_out = bus_wdata[NCH-1:0];
    else if (hit_masked) next_out = guarded_val;
    else if (hit_indiv)  next_out = indiv_val;
  end
endmodule

// File: rtl/gpo_route.sv
module gpo_route #(
  parameter int unsigned NCH = 8
) (
  input  logic [NCH-1:0] reg_val,
  input  logic [NCH-1:0] route_sel,
  input  logic [NCH-1:0] insn_src,
  output logic [NCH-1:0] pin_out
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_pin
    assign pin_out[ch] = route_sel[ch] ? insn_src[ch] : reg_val[ch];
  end
endmodule

// File: rtl/gpo_readback.sv
module gpo_readback
  import gpo_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NCH-1:0]    out_q,
  input  logic [NCH-1:0]    route_q,
  output logic [DATA_W-1:0] bus_rdata
);
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_STATUS))     bus_rdata[NCH-1:0] = out_q;
    else if (bus_addr == ADDR_W'(OFS_ROUTE)) bus_rdata[NCH-1:0] = route_q;
  end
endmodule

// File: rtl/gpo_multimode.sv
module gpo_multimode
  import gpo_pkg::*;
#(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    insn_src,
  output logic [NCH-1:0]    pin_out
);
  logic [NCH-1:0] out_q;
  logic [NCH-1:0] route_q;
  logic [NCH-1:0] next_out;
  logic           hit_direct, hit_masked, hit_indiv, hit_route, hit_none;

  gpo_wr_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cur_out   (out_q),
    .hit_direct(hit_direct),
    .hit_masked(hit_masked),
    .hit_indiv (hit_indiv),
    .hit_route (hit_route),
    .hit_none  (hit_none),
    .next_out  (next_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      route_q <= '0;
    end else begin
      out_q <= next_out;
      if (hit_route) route_q <= bus_wdata[NCH-1:0];
    end
  end

  gpo_route #(.NCH(NCH)) u_route (
    .reg_val  (out_q),
    .route_sel(route_q),
    .insn_src (insn_src),
    .pin_out  (pin_out)
  );

  gpo_readback #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .bus_addr (bus_addr),
    .out_q    (out_q),
    .route_q  (route_q),
    .bus_rdata(bus_rdata)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (out_q == '0) && (route_q == '0));

  assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_direct |=> out_q == $past(bus_wdata[NCH-1:0]));

  assert_guard_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_masked |=> (out_q & $past(bus_wdata[2*NCH-1:NCH])) ==
                   ($past(out_q) & $past(bus_wdata[2*NCH-1:NCH])));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    assert_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_indiv && (bus_wdata[2*ch +: 2] == 2'd3) |=> out_q[ch] != $past(out_q[ch]));
    assert_route_insn_R7: assert property (@(posedge clk) disable iff (!rst_n)
      route_q[ch] |-> pin_out[ch] == insn_src[ch]);
  end

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NCH] == '0);

  assert_unmapped_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_none |=> $stable(out_q) && $stable(route_q));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(out_q) && $stable(route_q));
endmodule

// File: tb/gpo_multimode_tb_top.sv
module gpo_multimode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  insn_src = '0;
  logic [7:0]  pin_out;

  int checks = 0;
  int errors = 0;
  int ref_out = 0;
  int ref_sel = 0;
  int cycles = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  gpo_multimode dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .insn_src(insn_src), .pin_out(pin_out)
  );

  // Behavioural reference: integers, arithmetic per requirement.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_out = 0;
      ref_sel = 0;
    end else if (bus_wr) begin
      if (bus_addr == 5'd0) ref_out = bus_wdata % 256;
      else if (bus_addr == 5'd4) begin
        int m, v;
        m = (bus_wdata / 256) % 256;
        v = bus_wdata % 256;
        ref_out = (ref_out & m) | (v & (255 - m));
      end else if (bus_addr == 5'd8) begin
        for (int c = 0; c < 8; c++) begin
          int code, b;
          code = (bus_wdata >> (2 * c)) & 3;
          b = (ref_out >> c) & 1;
          if (code == 1) b = 1;
          else if (code == 2) b = 0;
          else if (code == 3) b = 1 - b;
          ref_out = (ref_out & ~(1 << c)) | (b << c);
        end
      end else if (bus_addr == 5'd16) ref_sel = bus_wdata % 256;
    end
  end

  function automatic int ref_read(input int a);
    if (a == 12) return ref_out;
    if (a == 16) return ref_sel;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (running && rst_n) begin
      int ep, er;
      string tag;
      ep = (ref_out & ~ref_sel & 255) | (int'(insn_src) & ref_sel);
      er = ref_read(int'(bus_addr));
      tag = (bus_addr == 5'd12) ? "R5" : (bus_addr == 5'd16) ? "R6" : "R8";
      check(int'(pin_out) == ep, "R7 pins", int'(pin_out), ep);
      check(int'(bus_rdata) == er, tag, int'(bus_rdata), er);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_expect(input int a, input int exp, input string tag);
    @(negedge clk); #1;
    bus_addr = 5'(a);
    @(negedge clk);
    check(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R1 reset state
    rd_expect(12, 0, "R1 out reg");
    rd_expect(16, 0, "R1 route reg");
    check(pin_out == 8'h00, "R1 pins", int'(pin_out), 0);
    // R2 direct store, upper data ignored
    wr(0, 32'hFFFF_FFA5);
    rd_expect(12, 'hA5, "R2 direct");
    // R3 guarded stores: half, none, all protected
    wr(4, 32'h0000_F00F);
    rd_expect(12, 'hAF, "R3 half protect");
    wr(4, 32'h0000_0012);
    rd_expect(12, 'h12, "R3 no protect");
    wr(4, 32'h0000_FF00);
    rd_expect(12, 'h12, "R3 all protect");
    // R4 mixed codes: ch0 set ch1 clr ch2 inv ch3 hold ch4 inv ch5 set ch6 clr ch7 hold
    wr(8, 32'hFFFF_2739);
    rd_expect(12, 'h25, "R4 mixed codes");
    wr(8, 32'h0000_FFFF);
    rd_expect(12, 'hDA, "R4 all invert");
    // R8 write-only and unmapped reads, unmapped write
    rd_expect(0, 0, "R8 read 0x00");
    rd_expect(4, 0, "R8 read 0x04");
    rd_expect(8, 0, "R8 read 0x08");
    wr(20, 32'h0000_00FF);
    rd_expect(20, 0, "R8 read unmapped");
    rd_expect(12, 'hDA, "R8 unmapped write inert");
    // R6 / R7 routing
    wr(16, 32'hFFFF_FF0F);
    rd_expect(16, 'h0F, "R6 route readback");
    insn_src = 8'h3C;
    @(negedge clk);
    check(pin_out == 8'hDC, "R7 split route", int'(pin_out), 'hDC);
    // R9 strobe low: data on bus must not load
    @(negedge clk); #1;
    bus_addr = 5'd0; bus_wdata = 32'h0000_0000;
    repeat (4) @(negedge clk);
    check(pin_out == 8'hDC, "R9 idle hold", int'(pin_out), 'hDC);
    rd_expect(12, 'hDA, "R9 idle hold reg");
    // Random phase, compared each cycle
    for (int i = 0; i < 400; i++) begin
      int pick;
      @(negedge clk); #1;
      pick = $urandom_range(0, 6);
      bus_addr = (pick == 6) ? 5'($urandom_range(0, 31)) : 5'(pick * 4);
      bus_wr = $urandom_range(0, 1);
      bus_wdata = $urandom;
      insn_src = 8'($urandom);
    end
    @(negedge clk); #1;
    bus_wr = 1'b0;
    // R1 reset mid-run
    wr(16, 32'h0000_00AA);
    wr(0, 32'h0000_0055);
    @(negedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    check(pin_out == 8'h00, "R1 reset pins", int'(pin_out), 0);
    #1 rst_n = 1'b1;
    rd_expect(16, 0, "R1 route after reset");
    rd_expect(12, 0, "R1 out after reset");
    finish_run();
  end
endmodule